// File: doc/BRIEF.md
# Flash Command Decoder with Column-Area Pointer

This block sits behind the host-facing pins of an 8-bit NAND-style flash device. It watches each latched bus write and picks out the command bytes, which are the writes latched while the command-latch strobe is high. It follows the one-, two- and three-step command sequences the device accepts. For every completed operation it emits a single-cycle pulse. Bytes that do not form a legal sequence are discarded without any effect.

The block also keeps the column-area pointer that the read commands select. The pointer is one of the first half of the main page, the second half of the main page, or the spare area. The block presents this pointer together with the column offset at which the selected area starts. Address cycles are only flagged. Counting them, the array and data transfer are handled elsewhere.

The write strobe input is a synchronous one-cycle pulse that marks a rising write-enable edge, already brought into the `clk` domain. Every output is registered and appears on the clock edge after the strobe is sampled.

Top module: `nand_cmd_decoder`

## Requirements
- R1: A byte is decoded as a command only when `we_rise_i` and `cle_i` are both high in the same cycle. A strobe with `cle_i` low, or `cle_i` high without a strobe, produces no operation pulse.
- R2: Single-step commands raise exactly one pulse for one cycle, in the cycle after the strobe. The read pulse is raised by 00h, 01h and 50h. The signature pulse is raised by 90h and the status pulse by 70h. At most one operation pulse is high in any cycle.
- R3: 80h followed later by 10h raises the program pulse. Address and data writes (strobes with `cle_i` low) may occur between the two steps.
- R4: 60h followed later by D0h raises the erase pulse.
- R5: The sequence 00h, 8Ah, 10h raises the copy-back pulse. The 00h step also raises the read pulse at the time it is latched.
- R6: A confirm or middle byte with no matching pending step (10h, D0h, 8Ah) produces no pulse. Any byte outside the command set also produces no pulse.
- R7: When a sequence is pending, a different command byte aborts it. That byte is then decoded as the start of a new sequence. For example, 80h, 60h, D0h gives an erase, and 80h, 90h, 10h gives a signature pulse and no program pulse.
- R8: `area_o` encodes the pointer as 0 for the first main half, 1 for the second main half and 2 for the spare area. `col_msb_o` is 0, HALF_COLS or 2·HALF_COLS to match. 00h selects area 0 and 50h selects area 2, and each stays selected until another pointer command arrives.
- R9: 01h selects area 1. The pointer returns to area 0 in the first cycle `busy_i` is low after being high, unless a pointer command is latched in that same cycle.
- R10: While `busy_i` is high, only 70h and FFh are accepted. Every other command byte is dropped: no pulse is raised, and neither the pointer nor any pending step changes.
- R11: FFh raises the reset pulse, clears any pending step and sets the pointer to area 0.
- R12: `addr_o` pulses in the cycle after a strobe with `ale_i` high and `cle_i` low, and only when `busy_i` is low.
- R13: After `rst`, all pulses are low, `area_o` is 0 and `col_msb_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cle_i | input | 1 | Command latch strobe level |
| ale_i | input | 1 | Address latch strobe level |
| we_rise_i | input | 1 | One-cycle pulse for a write-enable rising edge |
| io_i | input | IO_W | Bus value latched with the strobe |
| busy_i | input | 1 | Device busy flag |
| read_o | output | 1 | Read command pulse |
| sig_o | output | 1 | Signature read pulse |
| status_o | output | 1 | Status read pulse |
| reset_o | output | 1 | Reset command pulse |
| prog_o | output | 1 | Confirmed page program pulse |
| erase_o | output | 1 | Confirmed block erase pulse |
| copyback_o | output | 1 | Confirmed copy-back pulse |
| addr_o | output | 1 | Address cycle marker pulse |
| area_o | output | 2 | Current column-area pointer |
| col_msb_o | output | COL_W | Starting column of the selected area |

## Verification
The hardest state to reach from the ports is a pending two-step sequence that survives a busy period. Reaching it takes a first step while idle, then raising busy and offering the confirm byte and a pointer command, both of which must be dropped. Busy is then lowered and the confirm is sent again. Only a program pulse at that point shows the pending step was kept. The automatic return from area 1 is similar: it needs a busy high-to-low transition with no pointer command in the same cycle. A long random phase, with busy toggling in runs and bytes drawn mostly from the command set, is therefore compared cycle by cycle against a behavioural model, after directed sequences for each of these cases.

// File: rtl/nand_cmd_pkg.sv
package nand_cmd_pkg;

  localparam logic [7:0] CODE_READ_A    = 8'h00;
  localparam logic [7:0] CODE_READ_B    = 8'h01;
  localparam logic [7:0] CODE_READ_C    = 8'h50;
  localparam logic [7:0] CODE_SIGNATURE = 8'h90;
  localparam logic [7:0] CODE_STATUS    = 8'h70;
  localparam logic [7:0] CODE_RESET     = 8'hFF;
  localparam logic [7:0] CODE_PROG_1    = 8'h80;
  localparam logic [7:0] CODE_CONFIRM   = 8'h10;
  localparam logic [7:0] CODE_ERASE_1   = 8'h60;
  localparam logic [7:0] CODE_ERASE_2   = 8'hD0;
  localparam logic [7:0] CODE_CBACK_2   = 8'h8A;

  typedef enum logic [2:0] {
    PEND_NONE,
    PEND_PROG,
    PEND_ERASE,
    PEND_CB1,
    PEND_CB2
  } pend_e;

  typedef enum logic [1:0] {
    AREA_A = 2'd0,
    AREA_B = 2'd1,
    AREA_C = 2'd2
  } area_e;

  typedef struct packed {
    logic rd;
    logic sig;
    logic stat;
    logic soft_rst;
    logic prog;
    logic erase;
    logic cback;
  } op_pulse_t;

endpackage

// File: rtl/nand_cmd_qualifier.sv
module nand_cmd_qualifier
  import nand_cmd_pkg::*;
#(
  parameter int IO_W = 8
) (
  input  logic            we_rise,
  input  logic            cle,
  input  logic            ale,
  input  logic            busy,
  input  logic [IO_W-1:0] io,
  output logic            cmd_v,
  output logic [IO_W-1:0] cmd_byte,
  output logic            addr_v
);

  logic busy_ok;

  // While busy, only status and reset get through.
  always_comb begin
    busy_ok  = (io == IO_W'(CODE_STATUS)) || (io == IO_W'(CODE_RESET));
    cmd_v    = we_rise && cle && (!busy || busy_ok);
    cmd_byte = io;
    addr_v   = we_rise && ale && !cle && !busy;
  end

endmodule

// File: rtl/nand_seq_tracker.sv
module nand_seq_tracker
  import nand_cmd_pkg::*;
#(
  parameter int IO_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_v,
  input  logic [IO_W-1:0] cmd_byte,
  output op_pulse_t       ops_o,
  output logic            ptr_set_o,
  output area_e           ptr_area_o
);

  pend_e     pend_q, pend_d;
  op_pulse_t ops_d, ops_q;

  always_comb begin
    pend_d     = pend_q;
    ops_d      = '0;
    ptr_set_o  = 1'b0;
    ptr_area_o = AREA_A;
    if (cmd_v) begin
      // Any accepted byte ends what was pending; the byte itself may start anew.
      pend_d = PEND_NONE;
      case (cmd_byte)
        IO_W'(CODE_RESET): begin
          ops_d.soft_rst = 1'b1;
          ptr_set_o      = 1'b1;
          ptr_area_o     = AREA_A;
        end
        IO_W'(CODE_READ_A): begin
          ops_d.rd   = 1'b1;
          ptr_set_o  = 1'b1;
          ptr_area_o = AREA_A;
          pend_d     = PEND_CB1;
        end
        IO_W'(CODE_READ_B): begin
          ops_d.rd   = 1'b1;
          ptr_set_o  = 1'b1;
          ptr_area_o = AREA_B;
        end
        IO_W'(CODE_READ_C): begin
          ops_d.rd   = 1'b1;
          ptr_set_o  = 1'b1;
          ptr_area_o = AREA_C;
        end
        IO_W'(CODE_SIGNATURE): ops_d.sig  = 1'b1;
        IO_W'(CODE_STATUS):    ops_d.stat = 1'b1;
        IO_W'(CODE_PROG_1):    pend_d     = PEND_PROG;
        IO_W'(CODE_ERASE_1):   pend_d     = PEND_ERASE;
        IO_W'(CODE_CBACK_2): begin
          if (pend_q == PEND_CB1) pend_d = PEND_CB2;
        end
        IO_W'(CODE_CONFIRM): begin
          if (pend_q == PEND_PROG) ops_d.prog  = 1'b1;
          if (pend_q == PEND_CB2)  ops_d.cback = 1'b1;
        end
        IO_W'(CODE_ERASE_2): begin
          if (pend_q == PEND_ERASE) ops_d.erase = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= PEND_NONE;
      ops_q  <= '0;
    end else begin
      pend_q <= pend_d;
      ops_q  <= ops_d;
    end
  end

  assign ops_o = ops_q;

  AST_OP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ops_q)); // R2
  AST_PROG_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    ops_q.prog |-> $past(pend_q == PEND_PROG)); // R3
  AST_CB_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    ops_q.cback |-> $past(pend_q == PEND_CB2)); // R5
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ops_q.soft_rst |-> pend_q == PEND_NONE); // R11

endmodule

// File: rtl/nand_area_pointer.sv
module nand_area_pointer
  import nand_cmd_pkg::*;
#(
  parameter int HALF_COLS = 256,
  parameter int COL_W     = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             set_v,
  input  area_e            set_area,
  output area_e            area_o,
  output logic [COL_W-1:0] col_o
);

  localparam logic [COL_W-1:0] COL_B = COL_W'(HALF_COLS);
  localparam logic [COL_W-1:0] COL_C = COL_W'(2 * HALF_COLS);

  area_e            area_q, area_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             busy_q;
  logic             busy_fell;

  always_comb begin
    busy_fell = busy_q && !busy;
    area_d    = area_q;
    if (set_v)
      area_d = set_area;
    else if (area_q == AREA_B && busy_fell)
      area_d = AREA_A;
    case (area_d)
      AREA_B:  col_d = COL_B;
      AREA_C:  col_d = COL_C;
      default: col_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    busy_q <= busy;
    if (rst) begin
      area_q <= AREA_A;
      col_q  <= '0;
    end else begin
      area_q <= area_d;
      col_q  <= col_d;
    end
  end

  assign area_o = area_q;
  assign col_o  = col_q;

  AST_COL_TRACKS_AREA: assert property (@(posedge clk) disable iff (rst)
    (area_q == AREA_C) |-> (col_q == COL_C)); // R8
  AST_C_STICKY: assert property (@(posedge clk) disable iff (rst)
    (area_q == AREA_C && !set_v) |=> (area_q == AREA_C)); // R8

endmodule

// File: rtl/nand_cmd_decoder.sv
module nand_cmd_decoder
  import nand_cmd_pkg::*;
#(
  parameter int IO_W       = 8,
  parameter int HALF_COLS  = 256,
  parameter int SPARE_COLS = 16,
  parameter int COL_W      = $clog2(2 * HALF_COLS + SPARE_COLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cle_i,
  input  logic             ale_i,
  input  logic             we_rise_i,
  input  logic [IO_W-1:0]  io_i,
  input  logic             busy_i,
  output logic             read_o,
  output logic             sig_o,
  output logic             status_o,
  output logic             reset_o,
  output logic             prog_o,
  output logic             erase_o,
  output logic             copyback_o,
  output logic             addr_o,
  output logic [1:0]       area_o,
  output logic [COL_W-1:0] col_msb_o
);

  logic            cmd_v;
  logic [IO_W-1:0] cmd_byte;
  logic            addr_v;
  logic            addr_q;
  op_pulse_t       ops;
  logic            ptr_set;
  area_e           ptr_area;
  area_e           area_cur;

  nand_cmd_qualifier #(.IO_W(IO_W)) qual_i (
    .we_rise (we_rise_i),
    .cle     (cle_i),
    .ale     (ale_i),
    .busy    (busy_i),
    .io      (io_i),
    .cmd_v   (cmd_v),
    .cmd_byte(cmd_byte),
    .addr_v  (addr_v)
  );

  nand_seq_tracker #(.IO_W(IO_W)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_v     (cmd_v),
    .cmd_byte  (cmd_byte),
    .ops_o     (ops),
    .ptr_set_o (ptr_set),
    .ptr_area_o(ptr_area)
  );

  nand_area_pointer #(.HALF_COLS(HALF_COLS), .COL_W(COL_W)) ptr_i (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy_i),
    .set_v   (ptr_set),
    .set_area(ptr_area),
    .area_o  (area_cur),
    .col_o   (col_msb_o)
  );

  always_ff @(posedge clk) begin
    if (rst) addr_q <= 1'b0;
    else     addr_q <= addr_v;
  end

  assign read_o     = ops.rd;
  assign sig_o      = ops.sig;
  assign status_o   = ops.stat;
  assign reset_o    = ops.soft_rst;
  assign prog_o     = ops.prog;
  assign erase_o    = ops.erase;
  assign copyback_o = ops.cback;
  assign addr_o     = addr_q;
  assign area_o     = area_cur;

  AST_NO_CMD_WITHOUT_CLE: assert property (@(posedge clk) disable iff (rst)
    (we_rise_i && !cle_i) |=> !(read_o || sig_o || status_o || reset_o ||
                                prog_o || erase_o || copyback_o)); // R1
  AST_BUSY_GATE: assert property (@(posedge clk) disable iff (rst)
    (we_rise_i && cle_i && busy_i) |=> !(read_o || sig_o || prog_o ||
                                         erase_o || copyback_o)); // R10
  AST_ERASE_CONFIRM: assert property (@(posedge clk) disable iff (rst)
    erase_o |-> $past(we_rise_i && cle_i && io_i == IO_W'(CODE_ERASE_2))); // R4
  AST_RESET_AREA: assert property (@(posedge clk) disable iff (rst)
    reset_o |-> area_o == 2'd0); // R11
  AST_B_FALLBACK: assert property (@(posedge clk) disable iff (rst)
    (area_o == 2'd1 && $past(busy_i) && !busy_i && !(we_rise_i && cle_i))
      |=> area_o == 2'd0); // R9
  AST_ADDR_ONLY_ALE: assert property (@(posedge clk) disable iff (rst)
    addr_o |-> $past(we_rise_i && ale_i && !cle_i && !busy_i)); // R12

endmodule

// File: tb/nand_cmd_decoder_tb.sv
module nand_cmd_decoder_tb_top;

  localparam int HALF  = 256;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cle = 1'b0;
  logic             ale = 1'b0;
  logic             we  = 1'b0;
  logic [7:0]       io  = 8'h00;
  logic             busy = 1'b0;
  logic             read_o, sig_o, status_o, reset_o, prog_o, erase_o, copyback_o, addr_o;
  logic [1:0]       area_o;
  logic [COL_W-1:0] col_msb_o;

  int n_vec = 0;
  int n_bad = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nand_cmd_decoder #(.IO_W(8), .HALF_COLS(HALF), .SPARE_COLS(16), .COL_W(COL_W)) dut_i (
    .clk(clk), .rst(rst), .cle_i(cle), .ale_i(ale), .we_rise_i(we), .io_i(io),
    .busy_i(busy), .read_o(read_o), .sig_o(sig_o), .status_o(status_o),
    .reset_o(reset_o), .prog_o(prog_o), .erase_o(erase_o), .copyback_o(copyback_o),
    .addr_o(addr_o), .area_o(area_o), .col_msb_o(col_msb_o)
  );

  // Behavioural reference: pend 0 none, 1 prog, 2 erase, 3 after 00h, 4 after 00h 8Ah
  int m_pend = 0;
  int m_area = 0;
  bit m_pbusy = 0;
  bit e_read, e_sig, e_stat, e_rst, e_prog, e_erase, e_cb, e_addr;

  always @(posedge clk) begin
    bit accept;
    bit pset;
    if (rst) begin
      m_pend = 0; m_area = 0;
      {e_read, e_sig, e_stat, e_rst, e_prog, e_erase, e_cb, e_addr} = '0;
    end else begin
      {e_read, e_sig, e_stat, e_rst, e_prog, e_erase, e_cb, e_addr} = '0;
      pset = 0;
      accept = we && cle && (!busy || io == 8'h70 || io == 8'hFF);
      if (accept) begin
        int old;
        old = m_pend;
        m_pend = 0;
        case (io)
          8'hFF: begin e_rst = 1; m_area = 0; pset = 1; end
          8'h00: begin e_read = 1; m_area = 0; pset = 1; m_pend = 3; end
          8'h01: begin e_read = 1; m_area = 1; pset = 1; end
          8'h50: begin e_read = 1; m_area = 2; pset = 1; end
          8'h90: e_sig = 1;
          8'h70: e_stat = 1;
          8'h80: m_pend = 1;
          8'h60: m_pend = 2;
          8'h8A: if (old == 3) m_pend = 4;
          8'h10: begin if (old == 1) e_prog = 1; if (old == 4) e_cb = 1; end
          8'hD0: if (old == 2) e_erase = 1;
          default: ;
        endcase
      end
      if (!pset && m_area == 1 && m_pbusy && !busy) m_area = 0;
      e_addr = we && ale && !cle && !busy;
    end
    m_pbusy = busy;
  end

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      check("R2 model read",      16'(read_o),     16'(e_read));
      check("R2 model sig",       16'(sig_o),      16'(e_sig));
      check("R2 model status",    16'(status_o),   16'(e_stat));
      check("R11 model reset",    16'(reset_o),    16'(e_rst));
      check("R3 model prog",      16'(prog_o),     16'(e_prog));
      check("R4 model erase",     16'(erase_o),    16'(e_erase));
      check("R5 model copyback",  16'(copyback_o), 16'(e_cb));
      check("R12 model addr",     16'(addr_o),     16'(e_addr));
      check("R8 model area",      16'(area_o),     16'(m_area));
      check("R8 model column",    16'(col_msb_o),  16'(m_area * HALF));
    end
  end

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk); cle = 1; ale = 0; we = 1; io = b;
    @(negedge clk); cle = 0; we = 0; io = 8'h00;
  endtask

  task automatic send_addr(input logic [7:0] b);
    @(negedge clk); cle = 0; ale = 1; we = 1; io = b;
    @(negedge clk); ale = 0; we = 0; io = 8'h00;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] pool [16] = '{8'h00, 8'h01, 8'h50, 8'h90, 8'h70, 8'hFF, 8'h80, 8'h10,
                              8'h60, 8'hD0, 8'h8A, 8'h10, 8'h00, 8'h8A, 8'h33, 8'hC5};
    repeat (3) @(negedge clk);
    // R13: reset state
    check("R13 pulses", 16'({read_o, sig_o, status_o, reset_o, prog_o, erase_o, copyback_o, addr_o}), 16'h0);
    check("R13 area", 16'(area_o), 16'h0);
    check("R13 column", 16'(col_msb_o), 16'h0);
    rst = 0;
    cmp_en = 1;

    // R1: strobe without CLE, CLE without strobe
    @(negedge clk); we = 1; io = 8'h70;
    @(negedge clk); we = 0; cle = 1;
    check("R1 strobe without cle", 16'(status_o), 16'h0);
    @(negedge clk); cle = 0;
    check("R1 cle without strobe", 16'(status_o), 16'h0);

    // R2: single-step pulses
    send_cmd(8'h90); check("R2 signature", 16'(sig_o), 16'h1);
    @(negedge clk);  check("R2 one cycle", 16'(sig_o), 16'h0);
    send_cmd(8'h70); check("R2 status", 16'(status_o), 16'h1);

    // R8: spare pointer sticky, column offsets
    send_cmd(8'h50); check("R2 read C", 16'(read_o), 16'h1);
    check("R8 area C", 16'(area_o), 16'h2);
    check("R8 column C", 16'(col_msb_o), 16'(2 * HALF));
    send_cmd(8'h90); send_cmd(8'h80); send_cmd(8'h10);
    check("R8 C sticky", 16'(area_o), 16'h2);
    send_cmd(8'h00); check("R8 area A", 16'(area_o), 16'h0);

    // R3: program with address cycles in between
    send_cmd(8'h80); send_addr(8'h00); send_addr(8'h12); send_addr(8'h34);
    check("R12 address marker", 16'(addr_o), 16'h1);
    send_cmd(8'h10); check("R3 program", 16'(prog_o), 16'h1);

    // R4: erase
    send_cmd(8'h60); send_addr(8'h01); send_cmd(8'hD0);
    check("R4 erase", 16'(erase_o), 16'h1);

    // R5: copy-back
    send_cmd(8'h00); check("R5 first step reads", 16'(read_o), 16'h1);
    send_cmd(8'h8A); send_cmd(8'h10);
    check("R5 copyback", 16'(copyback_o), 16'h1);

    // R6: orphan bytes
    send_cmd(8'h10); check("R6 lone confirm", 16'(prog_o | copyback_o), 16'h0);
    send_cmd(8'hD0); check("R6 lone erase confirm", 16'(erase_o), 16'h0);
    send_cmd(8'h8A); send_cmd(8'h10);
    check("R6 8A without 00", 16'(copyback_o), 16'h0);
    send_cmd(8'h33);
    check("R6 undefined", 16'({read_o, sig_o, status_o, reset_o, prog_o, erase_o, copyback_o}), 16'h0);

    // R7: abort and re-decode
    send_cmd(8'h80); send_cmd(8'h60); send_cmd(8'hD0);
    check("R7 redecode erase", 16'(erase_o), 16'h1);
    send_cmd(8'h80); send_cmd(8'h90);
    check("R7 new byte decoded", 16'(sig_o), 16'h1);
    send_cmd(8'h10); check("R7 program aborted", 16'(prog_o), 16'h0);

    // R9: area B falls back on busy end
    send_cmd(8'h01);
    check("R9 area B", 16'(area_o), 16'h1);
    check("R9 column B", 16'(col_msb_o), 16'(HALF));
    busy = 1;
    repeat (3) @(negedge clk);
    check("R9 held while busy", 16'(area_o), 16'h1);
    busy = 0;
    @(negedge clk);
    check("R9 fallback", 16'(area_o), 16'h0);

    // R10: busy drops commands, keeps pending step and pointer
    send_cmd(8'h80);
    busy = 1;
    send_cmd(8'h10); check("R10 confirm dropped", 16'(prog_o), 16'h0);
    send_cmd(8'h50); check("R10 pointer kept", 16'(area_o), 16'h0);
    check("R10 read dropped", 16'(read_o), 16'h0);
    send_addr(8'h55); check("R12 no address while busy", 16'(addr_o), 16'h0);
    busy = 0;
    send_cmd(8'h10); check("R10 pending kept", 16'(prog_o), 16'h1);
    busy = 1;
    send_cmd(8'h70); check("R10 status while busy", 16'(status_o), 16'h1);
    send_cmd(8'hFF); check("R10 reset while busy", 16'(reset_o), 16'h1);
    busy = 0;

    // R11: reset clears pending and pointer
    send_cmd(8'h50); send_cmd(8'h60); send_cmd(8'hFF);
    check("R11 reset pulse", 16'(reset_o), 16'h1);
    check("R11 area A", 16'(area_o), 16'h0);
    send_cmd(8'hD0); check("R11 pending cleared", 16'(erase_o), 16'h0);

    // Random phase against the model
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      we  = ($urandom_range(0, 2) == 0);
      cle = ($urandom_range(0, 1) == 1);
      ale = ($urandom_range(0, 3) == 0);
      io  = ($urandom_range(0, 7) == 0) ? 8'($urandom) : pool[$urandom_range(0, 15)];
      if ($urandom_range(0, 15) == 0) busy = ~busy;
    end
    @(negedge clk); we = 0; cle = 0; ale = 0; busy = 0;
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule